// File: doc/BRIEF.md
# Paced Serial DAC Word Sender

This block sits on the host side of a serial-input digital-to-analog converter. It sends one 16-bit sample per period of an internal sample timer. Each transfer is framed by an active-low framing output. A generated serial clock carries the bits, and each bit is valid at the rising edge of that clock. After the frame closes, a load strobe tells the converter to move the shifted word into its output latch. The strobe always sits the same number of system clocks after the timer expiry, so the converter's output updates are evenly spaced and free of jitter from the host.

Samples enter through a valid/ready handshake that is offered once per timer expiry. If no sample is waiting at that moment, the previous word is sent again and a sticky underrun flag is raised. All serial timing comes from a system-clock divider setting, `clk_div`, which gives the length of one serial-clock phase. The bit order is chosen per frame so that it matches the order the converter is strapped for.

Top module: `sdac_frame_tx`

## Requirements
- R1: While reset is held and immediately after it, `frame_n` = 1, `sclk` = 0, `sdo` = 0, `load` = 0, `s_ready` = 0 and `underrun` = 0.
- R2: Each frame holds `frame_n` low for exactly 32·D system clocks, where D = `clk_div` (0 is treated as 1), and `sclk` rises exactly 16 times while `frame_n` is low. `sclk` stays low whenever `frame_n` is high.
- R3: Within a frame, every low phase and every high phase of `sclk` lasts exactly D system clocks. `sdo` changes only while `sclk` is low, and it holds its value for at least D system clocks before each `sclk` rising edge.
- R4: With `msb_first` = 1, the bit sampled at the k-th rising edge (k = 0..15) is word bit 15−k. With `msb_first` = 0, it is word bit k.
- R5: `load` rises exactly 2·D system clocks after `frame_n` rises, stays high for exactly D system clocks, and is never high while `frame_n` is low.
- R6: The sample timer expires once every `period` system clocks (values below 2 are treated as 2). Each expiry that finds the block idle starts a frame, so back-to-back frames have `load` rising edges exactly `period` clocks apart. `period` must exceed 35·D+1.
- R7: `s_ready` is high for exactly one cycle per frame, in the cycle of the timer expiry that starts it. `s_data` is taken when `s_valid` is high in that cycle.
- R8: If `s_valid` is low at a frame start, the most recently accepted word is sent again. `underrun` then goes to 1 and stays at 1 until reset.
- R9: The word, bit order and D are captured at frame start. Changes to `s_data`, `msb_first` or `clk_div` during a frame do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| s_data | input | 16 | Sample word offered by the host |
| s_valid | input | 1 | Sample word is available |
| s_ready | output | 1 | Sample is taken this cycle (frame start) |
| msb_first | input | 1 | 1 = send bit 15 first, 0 = send bit 0 first |
| clk_div | input | 8 | System clocks per serial-clock phase |
| period | input | 16 | System clocks per sample |
| sclk | output | 1 | Serial clock, data valid at rising edge |
| frame_n | output | 1 | Active-low word framing |
| sdo | output | 1 | Serial data |
| load | output | 1 | Converter latch-update strobe |
| underrun | output | 1 | Sticky flag: a sample was missing at a frame start |

## Verification
A corrupted bit index or phase counter shows up within the same frame. The rising-edge count is no longer 16, a phase length differs from D, or the reassembled word differs from the one accepted. A wrong engine state or gap counter moves or stretches the `load` pulse, and this is visible one serial-clock period after the frame closes. A wrong timer count or holding register appears no later than the next sample: the spacing between `load` edges is off, or the resent word differs from the last accepted one.

// File: rtl/sdac_tx_pkg.sv
package sdac_tx_pkg;

    localparam int WORD_W = 16;
    localparam int DIV_W  = 8;
    localparam int PER_W  = 16;
    localparam int IDX_W  = $clog2(WORD_W);
    localparam int PC_W   = DIV_W + 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [DIV_W-1:0]  div_t;
    typedef logic [PER_W-1:0]  per_t;
    typedef logic [PC_W-1:0]   pc_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_GAP,
        ST_LOAD
    } eng_state_e;

    typedef struct packed {
        word_t word;
        logic  msb_first;
        div_t  half;
    } frame_cfg_t;

    function automatic div_t clamp_half(div_t d);
        return (d == '0) ? div_t'(1) : d;
    endfunction

    function automatic per_t clamp_period(per_t p);
        return (p < per_t'(2)) ? per_t'(2) : p;
    endfunction

    function automatic logic sel_bit(word_t w, idx_t i, logic msbf);
        idx_t j;
        j = msbf ? (idx_t'(WORD_W - 1) - i) : i;
        return w[j];
    endfunction

    function automatic pc_t phase_last(div_t h);
        return pc_t'(h) - pc_t'(1);
    endfunction

    function automatic pc_t gap_last(div_t h);
        return (pc_t'(h) << 1) - pc_t'(1);
    endfunction

endpackage

// File: rtl/sdac_rate_timer.sv
module sdac_rate_timer
    import sdac_tx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  per_t period,
    output logic tick
);

    per_t cnt_q;
    per_t lim;

    assign lim  = clamp_period(period) - per_t'(1);
    assign tick = !rst && (cnt_q >= lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q >= lim) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + per_t'(1);
        end
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R6

endmodule

// File: rtl/sdac_frame_engine.sv
module sdac_frame_engine
    import sdac_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  frame_cfg_t cfg_in,
    output logic       busy,
    output logic       sclk,
    output logic       frame_n,
    output logic       sdo,
    output logic       load
);

    eng_state_e state_q;
    frame_cfg_t cfg_q;
    pc_t        pc_q;
    idx_t       idx_q;
    logic       sclk_q;
    logic       frame_q;
    logic       load_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '{word: '0, msb_first: 1'b1, half: div_t'(1)};
            pc_q    <= '0;
            idx_q   <= '0;
            sclk_q  <= 1'b0;
            frame_q <= 1'b1;
            load_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cfg_q   <= cfg_in;
                        pc_q    <= '0;
                        idx_q   <= '0;
                        sclk_q  <= 1'b0;
                        frame_q <= 1'b0;
                        state_q <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (pc_q == phase_last(cfg_q.half)) begin
                        pc_q <= '0;
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;
                        end else begin
                            sclk_q <= 1'b0;
                            if (idx_q == idx_t'(WORD_W - 1)) begin
                                frame_q <= 1'b1;
                                state_q <= ST_GAP;
                            end else begin
                                idx_q <= idx_q + idx_t'(1);
                            end
                        end
                    end else begin
                        pc_q <= pc_q + pc_t'(1);
                    end
                end
                ST_GAP: begin
                    if (pc_q == gap_last(cfg_q.half)) begin
                        pc_q    <= '0;
                        load_q  <= 1'b1;
                        state_q <= ST_LOAD;
                    end else begin
                        pc_q <= pc_q + pc_t'(1);
                    end
                end
                default: begin
                    if (pc_q == phase_last(cfg_q.half)) begin
                        pc_q    <= '0;
                        load_q  <= 1'b0;
                        state_q <= ST_IDLE;
                    end else begin
                        pc_q <= pc_q + pc_t'(1);
                    end
                end
            endcase
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign sclk    = sclk_q;
    assign frame_n = frame_q;
    assign load    = load_q;
    assign sdo     = (state_q == ST_SHIFT) ? sel_bit(cfg_q.word, idx_q, cfg_q.msb_first) : 1'b0;

    AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        frame_n |-> !sclk); // R2

    AST_SDO_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(sdo)); // R3

    AST_LOAD_OUT_FRAME: assert property (@(posedge clk) disable iff (rst)
        load |-> frame_n); // R5

    AST_CFG_LATCHED: assert property (@(posedge clk) disable iff (rst)
        (!frame_n && $past(!frame_n)) |-> $stable(cfg_q)); // R9

endmodule

// File: rtl/sdac_frame_tx.sv
module sdac_frame_tx
    import sdac_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] s_data,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic              msb_first,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [PER_W-1:0]  period,
    output logic              sclk,
    output logic              frame_n,
    output logic              sdo,
    output logic              load,
    output logic              underrun
);

    logic       tick;
    logic       busy;
    logic       start;
    word_t      held_q;
    logic       ur_q;
    frame_cfg_t cfg;

    sdac_rate_timer u_timer (
        .clk    (clk),
        .rst    (rst),
        .period (period),
        .tick   (tick)
    );

    assign start   = tick && !busy;
    assign s_ready = start;

    assign cfg.word      = s_valid ? s_data : held_q;
    assign cfg.msb_first = msb_first;
    assign cfg.half      = clamp_half(clk_div);

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
            ur_q   <= 1'b0;
        end else if (start) begin
            if (s_valid) begin
                held_q <= s_data;
            end else begin
                ur_q <= 1'b1;
            end
        end
    end

    assign underrun = ur_q;

    sdac_frame_engine u_engine (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .cfg_in  (cfg),
        .busy    (busy),
        .sclk    (sclk),
        .frame_n (frame_n),
        .sdo     (sdo),
        .load    (load)
    );

    AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        s_ready |=> !s_ready); // R7

    AST_READY_IDLE_ONLY: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> (frame_n && !load)); // R7

    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun); // R8

endmodule

// File: tb/sim_sdac_frame_tx.sv
`timescale 1ns/1ps
module sim_sdac_frame_tx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] s_data = '0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic        msb_first = 1'b1;
    logic [7:0]  clk_div = 8'd10;
    logic [15:0] period = 16'd400;
    logic        sclk, frame_n, sdo, load, underrun;

    always #2 clk = ~clk;

    sdac_frame_tx u0 (
        .clk(clk), .rst(rst), .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
        .msb_first(msb_first), .clk_div(clk_div), .period(period),
        .sclk(sclk), .frame_n(frame_n), .sdo(sdo), .load(load), .underrun(underrun)
    );

    int n_chk = 0;
    int n_bad = 0;

    // monitor state
    int cyc = 0;
    logic pf = 1'b1, ps = 1'b0, psdo = 1'b0, pl = 1'b0;
    int f_start, f_end, frame_len, edges, last_edges, phase_len, sdo_age;
    int lo_min, lo_max, hi_min, hi_max, min_setup, bad_hi;
    int gap, load_w, last_lr, ld_int, ready_cnt, ready_snap, done_cnt = 0;
    bit lr_valid = 1'b0;
    logic [15:0] cap_seq, last_cap, prev_cap;

    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            pf = 1'b1; ps = 1'b0; psdo = 1'b0; pl = 1'b0;
            ready_cnt = 0; sdo_age = 0;
        end else begin
            if (s_ready) ready_cnt++;
            if (sdo != psdo) sdo_age = 1; else sdo_age++;
            if (pf && !frame_n) begin
                f_start = cyc; edges = 0; cap_seq = '0; phase_len = 1;
                lo_min = 1 << 30; lo_max = 0; hi_min = 1 << 30; hi_max = 0;
                min_setup = 1 << 30; bad_hi = 0;
            end else if (!pf) begin
                if (ps && sclk && (sdo != psdo)) bad_hi++;
                if (sclk != ps) begin
                    if (ps) begin
                        if (phase_len < hi_min) hi_min = phase_len;
                        if (phase_len > hi_max) hi_max = phase_len;
                    end else begin
                        if (phase_len < lo_min) lo_min = phase_len;
                        if (phase_len > lo_max) lo_max = phase_len;
                    end
                    phase_len = 1;
                    if (sclk) begin
                        if (edges < 16) cap_seq[edges] = sdo;
                        edges++;
                        if (sdo_age - 1 < min_setup) min_setup = sdo_age - 1;
                    end
                end else begin
                    phase_len++;
                end
            end
            if (!pf && frame_n) begin
                frame_len = cyc - f_start; f_end = cyc;
                prev_cap = last_cap; last_cap = cap_seq; last_edges = edges;
            end
            if (!pl && load) begin
                gap = cyc - f_end;
                if (lr_valid) ld_int = cyc - last_lr;
                last_lr = cyc; lr_valid = 1'b1;
            end
            if (pl && !load) begin
                load_w = cyc - last_lr;
                ready_snap = ready_cnt; ready_cnt = 0;
                done_cnt++;
            end
            pf = frame_n; ps = sclk; psdo = sdo; pl = load;
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic logic [15:0] decode(input logic [15:0] seq, input logic msbf);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) begin
            if (msbf) r[15-i] = seq[i]; else r[i] = seq[i];
        end
        return r;
    endfunction

    task automatic check_frame(input logic [15:0] w, input logic msbf, input int d, input logic exp_ur);
        chk(last_edges == 16, "R2 rising edges per frame", last_edges, 16);
        chk(frame_len == 32 * d, "R2 frame low length", frame_len, 32 * d);
        chk(lo_min == d && lo_max == d, "R3 low phase length", lo_max, d);
        chk(hi_min == d && hi_max == d, "R3 high phase length", hi_max, d);
        chk(min_setup >= d, "R3 data setup before rise", min_setup, d);
        chk(bad_hi == 0, "R3 sdo change while sclk high", bad_hi, 0);
        chk(decode(last_cap, msbf) == w, "R4 R9 captured word", int'(decode(last_cap, msbf)), int'(w));
        chk(gap == 2 * d, "R5 load delay after frame end", gap, 2 * d);
        chk(load_w == d, "R5 load width", load_w, d);
        chk(ready_snap == 1, "R7 ready pulses per frame", ready_snap, 1);
        chk(underrun == exp_ur, "R8 underrun flag", int'(underrun), int'(exp_ur));
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(frame_n == 1'b1, "R1 frame_n idle", int'(frame_n), 1);
        chk(sclk == 1'b0, "R1 sclk idle", int'(sclk), 0);
        chk(sdo == 1'b0, "R1 sdo idle", int'(sdo), 0);
        chk(load == 1'b0, "R1 load idle", int'(load), 0);
        chk(s_ready == 1'b0, "R1 s_ready idle", int'(s_ready), 0);
        chk(underrun == 1'b0, "R1 underrun clear", int'(underrun), 0);
    endtask

    task automatic t_frame(input logic [15:0] w, input logic msbf, input int d, input int per, input logic exp_ur);
        int d0;
        @(negedge clk);
        s_data = w; msb_first = msbf; clk_div = 8'(d); period = 16'(per); s_valid = 1'b1;
        while (!s_ready) @(negedge clk);
        d0 = done_cnt;
        @(negedge clk);
        // disturb inputs during the frame (R9)
        s_valid = 1'b0; s_data = ~w; msb_first = ~msbf; clk_div = 8'(d + 3);
        while (done_cnt == d0) @(negedge clk);
        check_frame(w, msbf, d, exp_ur);
        clk_div = 8'(d);
    endtask

    task automatic t_back_to_back(input logic [15:0] a, input logic [15:0] b, input int per);
        int d0;
        @(negedge clk);
        s_data = a; msb_first = 1'b1; clk_div = 8'd10; period = 16'(per); s_valid = 1'b1;
        while (!s_ready) @(negedge clk);
        @(negedge clk);
        s_data = b;
        while (!s_ready) @(negedge clk);
        d0 = done_cnt;
        @(negedge clk);
        s_valid = 1'b0;
        while (done_cnt == d0) @(negedge clk);
        chk(decode(prev_cap, 1'b1) == a, "R4 first of pair", int'(decode(prev_cap, 1'b1)), int'(a));
        chk(decode(last_cap, 1'b1) == b, "R4 second of pair", int'(decode(last_cap, 1'b1)), int'(b));
        chk(ld_int == per, "R6 load spacing equals period", ld_int, per);
    endtask

    task automatic t_underrun(input logic [15:0] last_w);
        int d0;
        @(negedge clk);
        s_valid = 1'b0; msb_first = 1'b1; clk_div = 8'd10; period = 16'd500;
        while (!s_ready) @(negedge clk);
        d0 = done_cnt;
        @(negedge clk);
        while (done_cnt == d0) @(negedge clk);
        chk(decode(last_cap, 1'b1) == last_w, "R8 previous word resent", int'(decode(last_cap, 1'b1)), int'(last_w));
        chk(underrun == 1'b1, "R8 underrun raised", int'(underrun), 1);
        chk(ready_snap == 1, "R7 ready pulse on underrun frame", ready_snap, 1);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_frame(16'hA5C3, 1'b1, 10, 400, 1'b0);
        t_frame(16'h1234, 1'b0, 10, 400, 1'b0);
        t_frame(16'hFFFF, 1'b1, 10, 400, 1'b0);
        t_frame(16'h0001, 1'b0, 10, 400, 1'b0);
        t_back_to_back(16'h5A5A, 16'h0F0F, 400);
        t_frame(16'h8000, 1'b1, 12, 500, 1'b0);
        t_back_to_back(16'hC001, 16'h3FFE, 500);
        t_underrun(16'h3FFE);
        t_frame(16'h7E81, 1'b0, 10, 500, 1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule